// File: doc/BRIEF.md
# Write-Completion Status Poller

After the host has written to a parallel EEPROM, the array runs an internal program cycle that lasts several milliseconds. This engine finds out when that cycle is over. It keeps issuing reads to one fixed address and checks the status the device encodes in the returned byte. It does not use a dedicated ready pin.

Two methods can be selected when a session is started. In bit-7 polling, the device returns the complement of bit 7 of the last loaded byte while it is busy. The true bit appears once the write has finished. In bit-6 toggling, bit 6 starts at 1 and flips on every read while the device is busy. It holds still once the device is finished, and the value it holds is not defined. A separate read sequencer takes care of the bus electrical timing. This block only raises a one-cycle read request and waits for a response strobe carrying the read byte. A cycle-count ceiling ends a session that never completes and reports it as a timeout.

Top module: `wr_done_poller`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_req_o`, `done_o` and `timeout_o` are low.
- R2: A `start_i` sampled while idle latches `tgt_addr_i`, `last_byte_i` and `mode_i`. A one-cycle `rd_req_o` follows in the next cycle, with `rd_addr_o` equal to the latched address.
- R3: Exactly one read is outstanding at a time. A response that does not complete the session causes a new one-cycle `rd_req_o` in the cycle after the response is sampled.
- R4: With `mode_i`=0 (bit-7 polling), the session completes on the first response whose bit 7 equals bit 7 of the latched last byte. A response whose bit 7 is inverted causes another read.
- R5: With `mode_i`=1 (bit-6 toggling), the first response of a session never completes it. A later response completes the session when its bit 6 equals bit 6 of the previous response.
- R6: Toggle completion does not depend on the value bit 6 settles at. Both a settled 0 and a settled 1 complete the session.
- R7: While a session runs, `rd_addr_o` stays constant. `start_i` and changes on `tgt_addr_i`, `last_byte_i` or `mode_i` are ignored.
- R8: If no completion has happened, `timeout_o` pulses for one cycle TMO_CYCLES cycles after the start was sampled. The engine then returns to idle and issues no further reads.
- R9: When a completing response is sampled on the same edge at which the ceiling expires, `done_o` pulses and `timeout_o` stays low.
- R10: A response strobe that arrives while no read is outstanding, including one that arrives after a timeout, is ignored. It produces no `done_o`, no read request, and no effect on the next session.
- R11: `done_o` is a one-cycle pulse in the cycle after the completing response is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a polling session (accepted only when idle) |
| tgt_addr_i | input | AW | Address to poll |
| last_byte_i | input | 8 | Last byte loaded into the device |
| mode_i | input | 1 | 0 = bit-7 polling, 1 = bit-6 toggle detection |
| rd_req_o | output | 1 | One-cycle read request to the read sequencer |
| rd_addr_o | output | AW | Address of the requested read |
| rd_vld_i | input | 1 | Read response strobe |
| rd_data_i | input | 8 | Byte returned with the response strobe |
| done_o | output | 1 | One-cycle pulse: program cycle finished |
| timeout_o | output | 1 | One-cycle pulse: ceiling exceeded, session abandoned |

## Verification
The hardest case to reach is the tie in R9: a completing response that lands on exactly the edge where the ceiling expires. The bench reaches it with a scripted responder of adjustable latency. With a latency of TMO_CYCLES-1 cycles, the only read of a bit-7 session returns on the expiry edge. One cycle more of latency turns the same session into a timeout, and that late response then serves as the stray strobe for R10. The toggle endings of R6 come from a device model whose busy-read count and settled bit-6 value can be chosen, so that the settled value either repeats or breaks the alternation.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    localparam int BYTE_W     = 8;
    localparam int POLL_BIT   = 7;   // complemented while busy
    localparam int TOGGLE_BIT = 6;   // alternates while busy

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } wdp_state_e;

    typedef enum logic {
        M_BIT7   = 1'b0,
        M_TOGGLE = 1'b1
    } wdp_mode_e;

    typedef struct packed {
        wdp_mode_e         mode;
        logic [BYTE_W-1:0] last;
    } wdp_cfg_t;

    function automatic logic bit7_settled(logic [BYTE_W-1:0] rd,
                                          logic [BYTE_W-1:0] last);
        return rd[POLL_BIT] == last[POLL_BIT];
    endfunction

    function automatic logic toggle_settled(logic have_prev, logic prev,
                                            logic [BYTE_W-1:0] rd);
        return have_prev && (rd[TOGGLE_BIT] == prev);
    endfunction

endpackage

// File: rtl/wdp_timer.sv
module wdp_timer #(
    parameter int LIMIT = 3_750_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/wdp_judge.sv
module wdp_judge
    import wdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  wdp_cfg_t          cfg,
    input  logic              rsp_take,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              finish
);
    logic prev_b6;
    logic have_prev;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_b6   <= 1'b0;
            have_prev <= 1'b0;
        end else if (rsp_take) begin
            prev_b6   <= rsp_data[TOGGLE_BIT];
            have_prev <= 1'b1;
        end
    end

    always_comb begin
        finish = 1'b0;
        if (rsp_take) begin
            if (cfg.mode == M_BIT7) begin
                finish = bit7_settled(rsp_data, cfg.last);
            end else begin
                finish = toggle_settled(have_prev, prev_b6, rsp_data);
            end
        end
    end
endmodule

// File: rtl/wdp_ctrl.sv
module wdp_ctrl
    import wdp_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     addr_in,
    input  logic [BYTE_W-1:0] last_in,
    input  logic              mode_in,
    input  logic              rsp_vld,
    input  logic              finish,
    input  logic              expire,
    output wdp_state_e        state,
    output wdp_cfg_t          cfg,
    output logic [AW-1:0]     addr_q,
    output logic              clear,
    output logic              rsp_take,
    output logic              done_q,
    output logic              tmo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cfg    <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_REQ;
                        addr_q    <= addr_in;
                        cfg.mode  <= wdp_mode_e'(mode_in);
                        cfg.last  <= last_in;
                    end
                end
                ST_REQ: begin
                    if (expire) begin
                        state <= ST_IDLE;
                        tmo_q <= 1'b1;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (finish) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (expire) begin
                        state <= ST_IDLE;
                        tmo_q <= 1'b1;
                    end else if (rsp_vld) begin
                        state <= ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign clear    = (state == ST_IDLE) && start;
    assign rsp_take = (state == ST_WAIT) && rsp_vld;
endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
    import wdp_pkg::*;
#(
    parameter int AW         = 17,
    parameter int TMO_CYCLES = 3_750_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] tgt_addr_i,
    input  logic [7:0]    last_byte_i,
    input  logic          mode_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_vld_i,
    input  logic [7:0]    rd_data_i,
    output logic          done_o,
    output logic          timeout_o
);
    wdp_state_e state;
    wdp_cfg_t   cfg;
    logic       clear, rsp_take, finish, expire, sess_busy;

    assign sess_busy = (state != ST_IDLE);

    wdp_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .addr_in(tgt_addr_i),
        .last_in(last_byte_i), .mode_in(mode_i), .rsp_vld(rd_vld_i),
        .finish(finish), .expire(expire), .state(state), .cfg(cfg),
        .addr_q(rd_addr_o), .clear(clear), .rsp_take(rsp_take),
        .done_q(done_o), .tmo_q(timeout_o)
    );

    wdp_judge u_judge (
        .clk(clk), .rst(rst), .clear(clear), .cfg(cfg),
        .rsp_take(rsp_take), .rsp_data(rd_data_i), .finish(finish)
    );

    wdp_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .clear(clear), .run(sess_busy), .expire(expire)
    );

    assign rd_req_o = (state == ST_REQ);
endmodule

// File: rtl/wdp_checker.sv
module wdp_checker #(
    parameter int AW         = 17,
    parameter int TMO_CYCLES = 3_750_000
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_vld_i,
    input logic          done_o,
    input logic          timeout_o,
    input logic          sess_busy
);
    int unsigned win;

    always_ff @(posedge clk) begin
        if (rst || !sess_busy) win <= 0;
        else                   win <= win + 1;
    end

    a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

    a_r11_done_after_rsp: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(rd_vld_i));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> (!timeout_o && !rd_req_o));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (sess_busy && $past(sess_busy)) |-> $stable(rd_addr_o));

    a_r8_window: assert property (@(posedge clk) disable iff (rst)
        sess_busy |-> (win < TMO_CYCLES));

    a_r10_stray_ignored: assert property (@(posedge clk) disable iff (rst)
        (!sess_busy && rd_vld_i) |=> !done_o);
endmodule

bind wr_done_poller wdp_checker #(.AW(AW), .TMO_CYCLES(TMO_CYCLES)) u_wdp_chk (
    .clk(clk), .rst(rst), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_vld_i(rd_vld_i), .done_o(done_o), .timeout_o(timeout_o),
    .sess_busy(sess_busy)
);

// File: tb/wr_done_poller_bench.sv
module wr_done_poller_bench;
    localparam int AW  = 17;
    localparam int TMO = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] tgt_addr_i = '0;
    logic [7:0]    last_byte_i = '0;
    logic          mode_i = 1'b0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_vld_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          done_o, timeout_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // device model knobs
    bit       m_mode = 0;
    logic [7:0] m_last = '0;
    int       m_busy = 0;
    bit       m_fin6 = 0;
    int       m_lat = 1;
    int       m_idx = 0;
    bit       stray = 0;
    bit       pend = 0;
    int       cd = 0;

    always #2 clk = ~clk;

    wr_done_poller #(.AW(AW), .TMO_CYCLES(TMO)) u_wr_done_poller (
        .clk(clk), .rst(rst), .start_i(start_i), .tgt_addr_i(tgt_addr_i),
        .last_byte_i(last_byte_i), .mode_i(mode_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    function automatic bit tog_b6(int i);
        return (i < m_busy) ? ~i[0] : m_fin6;
    endfunction

    function automatic logic [7:0] model(int i);
        if (!m_mode)
            return (i < m_busy) ? {~m_last[7], i[6:0] ^ 7'h2A} : m_last;
        return {i[0], tog_b6(i), i[5:0]};
    endfunction

    // responder: answers each request m_lat cycles after it is sampled
    initial forever begin
        @(negedge clk);
        rd_vld_i = 1'b0;
        if (pend) begin
            cd--;
            if (cd == 0) begin
                rd_vld_i  = 1'b1;
                rd_data_i = model(m_idx);
                m_idx++;
                pend = 0;
            end
        end
        if (rd_req_o) begin
            pend = 1;
            cd   = m_lat;
        end
        if (stray) begin
            rd_vld_i  = 1'b1;
            rd_data_i = 8'hFF;
            stray = 0;
        end
    end

    task automatic check(bit ok, string rq, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // one polling session; expectations come from the requirement rules
    task automatic run_poll(string rq, bit mode, logic [AW-1:0] a, logic [7:0] lb,
                            int busy_n, bit fin6, int lat, bit disturb);
        int k, done_rel, tmo_rel, exp_reqs, span;
        int reqs = 0, bad_addr = 0, done_at = -1, tmo_at = -1, dones = 0, tmos = 0;
        bit exp_done;
        m_mode = mode; m_last = lb; m_busy = busy_n; m_fin6 = fin6;
        m_lat = lat; m_idx = 0;
        if (!mode) k = busy_n + 1;
        else begin
            k = 0;
            for (int i = 1; i < 1000 && k == 0; i++)
                if (tog_b6(i) == tog_b6(i - 1)) k = i + 1;
        end
        done_rel = k * (lat + 1) + 1;
        tmo_rel  = TMO + 1;
        exp_done = (done_rel <= tmo_rel);
        exp_reqs = 0;
        if (exp_done) exp_reqs = k;
        else for (int j = 0; 1 + j * (lat + 1) <= TMO; j++) exp_reqs++;
        span = (exp_done ? done_rel : tmo_rel) + lat + 4;

        @(negedge clk);
        start_i = 1'b1; tgt_addr_i = a; last_byte_i = lb; mode_i = mode;
        for (int n = 1; n <= span; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (disturb && n == 3) begin
                start_i = 1'b1; tgt_addr_i = ~a; last_byte_i = ~lb; mode_i = ~mode;
            end
            if (rd_req_o) begin
                reqs++;
                if (rd_addr_o != a) bad_addr++;
            end
            if (done_o) begin dones++; if (done_at < 0) done_at = n; end
            if (timeout_o) begin tmos++; if (tmo_at < 0) tmo_at = n; end
        end
        start_i = 1'b0;
        check(bad_addr == 0, "R7", "reads at wrong address", bad_addr, 0);
        check(reqs == exp_reqs, rq, "read requests issued", reqs, exp_reqs);
        if (exp_done) begin
            check(dones == 1 && done_at == done_rel, rq, "done cycle", done_at, done_rel);
            check(tmos == 0, "R9", "timeout pulses", tmos, 0);
        end else begin
            check(tmos == 1 && tmo_at == tmo_rel, "R8", "timeout cycle", tmo_at, tmo_rel);
            check(dones == 0, "R8", "done pulses", dones, 0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o, "R1", "outputs in reset",
              {rd_req_o, done_o, timeout_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_req_o && !done_o && !timeout_o, "R1", "outputs after reset",
              {rd_req_o, done_o, timeout_o}, 0);
    endtask

    task automatic t_first_req();
        @(negedge clk);
        start_i = 1'b1; tgt_addr_i = 17'h15555; mode_i = 1'b0; last_byte_i = 8'h80;
        m_mode = 0; m_last = 8'h80; m_busy = 0; m_lat = 1; m_idx = 0;
        @(negedge clk);
        start_i = 1'b0;
        check(rd_req_o == 1'b1, "R2", "request after start", rd_req_o, 1);
        check(rd_addr_o == 17'h15555, "R2", "request address", rd_addr_o, 17'h15555);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_stray();
        int evt = 0;
        @(negedge clk);
        stray = 1;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            if (done_o || timeout_o || rd_req_o) evt++;
        end
        check(evt == 0, "R10", "reaction to idle strobe", evt, 0);
    endtask

    initial begin
        t_reset();
        t_first_req();
        run_poll("R4", 1'b0, 17'h00100, 8'h3C, 0, 1'b0, 1, 1'b0);
        run_poll("R4", 1'b0, 17'h1ABCD, 8'hA5, 5, 1'b0, 2, 1'b0);
        run_poll("R3", 1'b0, 17'h00042, 8'h12, 2, 1'b0, 3, 1'b0);
        run_poll("R6", 1'b1, 17'h00777, 8'h55, 3, 1'b1, 1, 1'b0);
        run_poll("R6", 1'b1, 17'h00778, 8'h55, 3, 1'b0, 2, 1'b0);
        run_poll("R5", 1'b1, 17'h00010, 8'h00, 0, 1'b0, 1, 1'b0);
        run_poll("R7", 1'b0, 17'h0AAAA, 8'hC3, 4, 1'b0, 2, 1'b1);
        run_poll("R8", 1'b0, 17'h01234, 8'h80, 100, 1'b0, 2, 1'b0);
        run_poll("R8", 1'b1, 17'h01235, 8'h80, 100, 1'b0, 1, 1'b0);
        run_poll("R9", 1'b0, 17'h00005, 8'hFE, 0, 1'b0, TMO - 1, 1'b0);
        run_poll("R10", 1'b0, 17'h00006, 8'hFE, 0, 1'b0, TMO, 1'b0);
        t_stray();
        run_poll("R10", 1'b1, 17'h00009, 8'h00, 2, 1'b1, 1, 1'b0);
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end
endmodule